// File: doc/BRIEF.md
# Clock-Gated Low-Power Pixel FIR Filter

This block is a direct-form FIR filter that takes a stream of 8-bit unsigned pixels. Each accepted sample produces one full-precision filtered result. The filter saves switching activity in its delay line.

Every tap register is split into two parts:

- A low-order part that loads on every accepted sample.
- A high-order part that loads only when its contents would actually change. Because neighbouring pixels in an image are usually close in value, the upper bits of successive samples are normally equal, so this part rarely loads.

Only one comparator makes the high-order load decision. It sits at the first tap and compares the incoming upper bits with the upper bits stored there. The decision then moves down the delay line one tap per accepted sample, so every later tap reuses it. No tap has its own change detector. Gating is modelled as a synchronous load enable.

The coefficients are fixed parameters. The per-tap high-order load strobes are brought out so the update activity can be observed.

Top module: `cg_fir_top`

## Requirements
- R1: After `rst_ni` is asserted, `valid_o` is 0, `res_o` is 0 and every tap holds 0. As a result, the first result after reset equals coefficient 0 times the first pixel.
- R2: `valid_o` pulses high exactly two clock cycles after each cycle in which `valid_i` is high. `res_o` changes only in cycles where `valid_o` is high.
- R3: Each result equals the sum over k = 0..7 of c[k]·x[n−k], where x[n] is the newest accepted pixel. Pixels are treated as unsigned and coefficients as signed two's complement. Coefficient k sits in bits [8k+7:8k] of `COEFS`. Samples that did not exist after reset count as 0. The result must be bit-identical to an ungated FIR.
- R4: `hi_load_o[0]` is high exactly when `valid_i` is high and `pix_i[7:4]` differs from the upper 4 bits of the previous accepted pixel (0 after reset).
- R5: For k ≥ 1, `hi_load_o[k]` is high exactly when `valid_i` is high and the tap k−1 load decision, as it stood one accepted sample earlier, was set. Fewer than k accepted samples after reset, `hi_load_o[k]` is high with every valid sample.
- R6: When `valid_i` is low, no tap changes, `hi_load_o` is all zeros and no result is produced. Gaps between samples do not disturb later results.
- R7: `res_o` is 20 bits wide and signed, so extreme inputs (pixel 255 against coefficients −128 and 127) never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel strobe; a sample is accepted on each rising edge where it is high |
| pix_i | input | 8 | Unsigned pixel |
| valid_o | output | 1 | Result strobe |
| res_o | output | 20 | Signed filtered result |
| hi_load_o | output | 8 | Per-tap high-order load strobe for the current cycle |

## Verification
The assertions take for granted that `valid_i` and `pix_i` hold known values whenever reset is released, and that a sample is present only in cycles with `valid_i` high. The key check, that a tap never skips a high-order load while its incoming upper bits differ from its stored ones, holds only under that assumption. The stimulus changes inputs only on falling edges and never leaves them unknown. It mixes:

- flat regions, so the upper bits repeat;
- slow ramps, so the upper bits step occasionally;
- random pixels, so the upper bits toggle often;
- idle gaps and a reset in the middle of the run.

Together these drive every gating decision both ways.

// File: rtl/cg_fir_pkg.sv
`timescale 1ns/1ps
package cg_fir_pkg;
  function automatic int unsigned acc_width(input int unsigned data_w,
                                            input int unsigned coef_w,
                                            input int unsigned taps);
    return data_w + coef_w + 1 + $clog2(taps);
  endfunction
endpackage

// File: rtl/cg_fir_chg_det.sv
`timescale 1ns/1ps
module cg_fir_chg_det #(
  parameter int unsigned HI_W = 4
) (
  input  logic            valid_i,
  input  logic [HI_W-1:0] hi_new_i,
  input  logic [HI_W-1:0] hi_old_i,
  output logic            load_o
);
  logic diff;
  assign diff   = |(hi_new_i ^ hi_old_i);
  assign load_o = valid_i & diff;
endmodule

// File: rtl/cg_fir_tap.sv
`timescale 1ns/1ps
module cg_fir_tap #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hi_en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              hi_load_o
);
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            hi_ld;

  assign hi_ld     = valid_i & hi_en_i;
  assign hi_load_o = hi_ld;
  assign q_o       = {hi_q, lo_q};

  // low part: every accepted sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (valid_i) lo_q <= d_i[LO_W-1:0];
  end

  // high part: enable stands in for a gated clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (hi_ld) hi_q <= d_i[DATA_W-1:LO_W];
  end

  // R3: a suppressed load must never drop a change
  a_r3_skip_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hi_en_i) |-> (d_i[DATA_W-1:LO_W] == hi_q));

  a_r3_tap_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (q_o == $past(d_i)));

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(q_o));
endmodule

// File: rtl/cg_fir_mac.sv
`timescale 1ns/1ps
module cg_fir_mac
  import cg_fir_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TAPS   = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  localparam int unsigned ACC_W = acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [TAPS*DATA_W-1:0] taps_i,
  output logic                   valid_o,
  output logic signed [ACC_W-1:0] res_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W + 1;

  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0]  sum;
  logic                     stg_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_prod
    logic signed [DATA_W:0]   px;
    logic signed [COEF_W-1:0] cf;
    assign px      = $signed({1'b0, taps_i[k*DATA_W +: DATA_W]});
    assign cf      = $signed(COEFS[k*COEF_W +: COEF_W]);
    assign prod[k] = PROD_W'(px * cf);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + ACC_W'(prod[k]);
  end

  // stage flag: taps updated last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      stg_q   <= valid_i;
      valid_o <= stg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (stg_q) res_o <= sum;
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  a_r2_res_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> valid_o);
endmodule

// File: rtl/cg_fir_top.sv
`timescale 1ns/1ps
module cg_fir_top
  import cg_fir_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO_W   = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TAPS   = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 64'h14F9_097F_8005_FE01,
  localparam int unsigned ACC_W = acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [DATA_W-1:0]       pix_i,
  output logic                    valid_o,
  output logic signed [ACC_W-1:0] res_o,
  output logic [TAPS-1:0]         hi_load_o
);
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0]      tap_q [TAPS];
  logic [TAPS*DATA_W-1:0] taps_flat;
  logic [TAPS-1:0]        hi_en;
  logic                   first_ld;

  cg_fir_chg_det #(.HI_W(HI_W)) u_chg (
    .valid_i (valid_i),
    .hi_new_i(pix_i[DATA_W-1:LO_W]),
    .hi_old_i(tap_q[0][DATA_W-1:LO_W]),
    .load_o  (first_ld)
  );

  assign hi_en[0] = first_ld;

  // decision rides down the line one accepted sample per tap
  for (genvar k = 1; k < TAPS; k++) begin : g_en
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q <= 1'b1;
      else if (valid_i) en_q <= hi_en[k-1];
    end
    assign hi_en[k] = en_q;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [DATA_W-1:0] d;
    if (k == 0) begin : g_head
      assign d = pix_i;
    end else begin : g_body
      assign d = tap_q[k-1];
    end
    cg_fir_tap #(.DATA_W(DATA_W), .LO_W(LO_W)) u_tap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .hi_en_i  (hi_en[k]),
      .d_i      (d),
      .q_o      (tap_q[k]),
      .hi_load_o(hi_load_o[k])
    );
    assign taps_flat[k*DATA_W +: DATA_W] = tap_q[k];
  end

  cg_fir_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(COEFS)
  ) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .taps_i (taps_flat),
    .valid_o(valid_o),
    .res_o  (res_o)
  );

  a_r6_no_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (hi_load_o == '0));

  a_r5_propagate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && first_ld) |=> hi_en[1]);

  a_r1_reset_out: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));
endmodule

// File: tb/sim_cg_fir_top.sv
`timescale 1ns/1ps
module sim_cg_fir_top;
  localparam int TAPS = 8;
  localparam logic [63:0] COEFS = 64'h14F9_097F_8005_FE01;
  int cf [TAPS] = '{1, -2, 5, -128, 127, 9, -7, 20};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [7:0]        pix_i = '0;
  logic              valid_o;
  logic signed [19:0] res_o;
  logic [TAPS-1:0]   hi_load_o;

  cg_fir_top #(.COEFS(COEFS)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pix_i(pix_i),
    .valid_o(valid_o), .res_o(res_o), .hi_load_o(hi_load_o)
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0, hi_loads = 0, hi_slots = 0;
  logic [7:0] hist [TAPS];
  bit en_m [TAPS];
  logic signed [19:0] exp_q [$];
  int stamp_q [$];

  always @(posedge clk_i) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d @cyc %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < TAPS; k++) begin
      hist[k] = '0;
      en_m[k] = 1'b1;
    end
  endtask

  task automatic drive(input logic [7:0] x);
    logic [TAPS-1:0] exp_ld;
    longint s;
    bit en0;
    @(negedge clk_i);
    valid_i = 1'b1;
    pix_i   = x;
    en0 = (x[7:4] != hist[0][7:4]);
    exp_ld[0] = en0;
    for (int k = 1; k < TAPS; k++) exp_ld[k] = en_m[k];
    #1;
    check(hi_load_o == exp_ld, "R4/R5 hi_load", hi_load_o, exp_ld);
    hi_loads += $countones(hi_load_o);
    hi_slots += TAPS;
    for (int k = TAPS-1; k > 0; k--) begin
      hist[k] = hist[k-1];
      en_m[k] = (k == 1) ? en0 : en_m[k-1];
    end
    hist[0] = x;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(cf[k]) * longint'(hist[k]);
    exp_q.push_back(20'(s));
    stamp_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      pix_i   = 8'hA5;
      #1;
      check(hi_load_o == '0, "R6 idle hi_load", hi_load_o, 0);
    end
  endtask

  // monitor: pops scoreboard as results appear
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid_o", 1, 0);
      end else begin
        logic signed [19:0] e;
        int st;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        check(res_o == e, "R3/R7 result", res_o, e);
        check(cyc == st + 2, "R2 latency", cyc - st, 2);
      end
    end
  end

  task automatic drain();
    idle(4);
    check(exp_q.size() == 0, "R2 pending results", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    model_reset();
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 reset valid_o", valid_o, 0);
    check(res_o == '0, "R1 reset res_o", res_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: first output is c0*x with zeroed history
    drive(8'hC3);
    drain();
    // flat region: upper bits repeat
    for (int i = 0; i < 40; i++) drive(8'h70 + 8'(i % 6));
    // slow ramp
    for (int i = 0; i < 80; i++) drive(8'(i * 3));
    // R6 gaps interleaved
    for (int i = 0; i < 20; i++) begin
      drive(8'h40 + 8'(i));
      idle(1 + i % 3);
    end
    // R7 extremes
    for (int i = 0; i < 16; i++) drive((i % 2) ? 8'hFF : 8'h00);
    for (int i = 0; i < 12; i++) drive(8'hFF);
    // noisy region
    for (int i = 0; i < 60; i++) drive(8'($urandom));
    drain();
    // mid-run reset, R1 again
    do_reset();
    drive(8'h9E);
    drive(8'h9F);
    for (int i = 0; i < 10; i++) drive(8'h90 + 8'(i));
    drain();
    $display("high-part loads %0d of %0d tap slots", hi_loads, hi_slots);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule